// File: doc/BRIEF.md
# Tagged Transmit Byte Queue with Refill Threshold

This block buffers bytes that a processor writes toward a bit-serial framing transmitter. It holds up to 19 entries. Each entry carries the data byte and two marker bits. One marker says the byte closes a packet. The other says the transmitter must send an abort sequence in place of the byte. The packet-end marker is taken from a control input that is sampled with the write. The abort marker comes from a one-shot request register: software arms it first, the next accepted write carries the marker, and the register then clears by itself.

The drain side offers the oldest entry together with its markers. It works as a first-word-fall-through stream. The fill level is visible at all times. A threshold interrupt fires when draining brings the level down from five entries to four, so software can answer each interrupt with a burst of at most 15 writes without overrunning the queue. A write that arrives while the queue is full is discarded and sets a sticky overflow flag. A status-read strobe clears both the interrupt and the overflow flag.

Back-pressure rules: on the write side, `wr_ready` is low exactly when all 19 entries are occupied. A `wr_valid` that is raised while `wr_ready` is low is dropped, not held, and it is reported through `ovf`. On the drain side, an entry leaves on each clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` has no effect while the queue is empty.

Top module: `tx_tag_fifo`

## Requirements
- R1: After a synchronous reset, `level` is 0, `empty` is 1, `rd_valid` is 0, `wr_ready` is 1, and `irq`, `ovf` and `fa_pending` are all 0.
- R2: The queue accepts exactly 19 writes while nothing is drained. `wr_ready` is low whenever `level` equals 19 and high otherwise.
- R3: Bytes leave in the order they were accepted. The oldest byte is presented on `rd_data` while `rd_valid` is high, with no extra read latency.
- R4: `rd_eop` of an entry equals the value `wr_eop` had on the edge where that entry was accepted.
- R5: A `fa_set` pulse makes `fa_pending` 1 on the next cycle. The next accepted write stores `rd_abort`=1 for its entry and clears `fa_pending`, unless `fa_set` is high on that same edge, in which case `fa_pending` stays 1. Entries written while `fa_pending` is 0 have `rd_abort`=0. A dropped write does not consume the request.
- R6: A write attempted while `level` is 19 does not change `level` or the stored entries, and it sets `ovf` to 1 on the next cycle. `ovf` stays set until a status read.
- R7: `irq` becomes 1 on the cycle after an edge where `level` goes from 5 to 4. Rising through 4 while filling never sets `irq`, and `irq` stays set until a status read.
- R8: A `stat_rd` pulse clears `irq` and `ovf` on the next cycle. If a set condition occurs on the same edge, the set wins and the flag stays 1.
- R9: A write and a drain on the same edge, with the queue neither full nor empty, leave `level` unchanged.
- R10: `level` always equals the number of accepted writes minus the number of drained entries since reset.
- R11: `rd_ready` while the queue is empty has no effect. `level` stays 0 and no entry is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor write strobe |
| wr_ready | output | 1 | Space available (queue not full) |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Packet-end control bit, sampled with the write |
| fa_set | input | 1 | Arms the one-shot abort request |
| fa_pending | output | 1 | Abort request armed, waiting for the next write |
| rd_valid | output | 1 | Oldest entry is available |
| rd_ready | input | 1 | Transmitter takes the oldest entry |
| rd_data | output | 8 | Oldest byte |
| rd_eop | output | 1 | Packet-end marker of the oldest entry |
| rd_abort | output | 1 | Abort marker of the oldest entry |
| empty | output | 1 | No entries stored |
| level | output | 5 | Number of stored entries |
| stat_rd | input | 1 | Status-read strobe, clears irq and ovf |
| irq | output | 1 | Sticky refill-threshold interrupt |
| ovf | output | 1 | Sticky dropped-write flag |

## Verification
The hardest case to reach is the interrupt firing from a specific downward crossing on the same edge as something else: a status read, a write that keeps the level steady, or an abort request armed on the same edge as its consuming write. The bench reaches these situations in two ways. Directed sequences fill the queue to each level from 1 to 18 and then apply a combined write and drain there. A long run of arithmetically generated strobe patterns then keeps the level oscillating around the threshold and the full boundary. A cycle-level reference, built from the requirements, predicts every output on every cycle.

// File: rtl/tx_tag_fifo_pkg.sv
package tx_tag_fifo_pkg;
  // Per-entry marker bits stored beside each byte
  typedef struct packed {
    logic eop;
    logic abort;
  } tx_tag_t;

  localparam int TAG_W = $bits(tx_tag_t);
endpackage

// File: rtl/tx_tag_fifo_store.sv
module tx_tag_fifo_store
  import tx_tag_fifo_pkg::*;
#(
  parameter int DEPTH  = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] in_data,
  input  tx_tag_t           in_tag,
  output logic [DATA_W-1:0] out_data,
  output tx_tag_t           out_tag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + TAG_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [ENT_W-1:0] slot [DEPTH];

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= advance(wr_ptr);
      if (pop)  rd_ptr <= advance(rd_ptr);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[g] <= '0;
      else if (push && (wr_ptr == PTR_W'(g)))
        slot[g] <= {in_tag, in_data};
    end
  end

  always_comb begin
    {out_tag, out_data} = slot[rd_ptr];
  end
endmodule

// File: rtl/tx_tag_fifo_level.sv
module tx_tag_fifo_level #(
  parameter int DEPTH    = 19,
  parameter int LOW_MARK = 4,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] MARK_CNT  = CNT_W'(LOW_MARK);
  localparam logic [CNT_W-1:0] ABOVE_CNT = CNT_W'(LOW_MARK + 1);

  logic [CNT_W-1:0] count_nxt;
  logic             crossing;

  always_comb begin
    count_nxt = count;
    if (push && !pop)      count_nxt = count + CNT_W'(1);
    else if (pop && !push) count_nxt = count - CNT_W'(1);
    crossing = (count == ABOVE_CNT) && (count_nxt == MARK_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      count <= count_nxt;
      if (crossing)      irq <= 1'b1;
      else if (stat_clr) irq <= 1'b0;
    end
  end

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
endmodule

// File: rtl/tx_tag_fifo_ctrl.sv
module tx_tag_fifo_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_try,
  input  logic accepted,
  input  logic fa_set,
  input  logic stat_clr,
  output logic fa_pending,
  output logic ovf
);
  logic dropped;
  assign dropped = wr_try && !accepted;

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_pending <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      if (fa_set)        fa_pending <= 1'b1;
      else if (accepted) fa_pending <= 1'b0;
      if (dropped)       ovf <= 1'b1;
      else if (stat_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_tag_fifo.sv
module tx_tag_fifo
  import tx_tag_fifo_pkg::*;
#(
  parameter int DEPTH    = 19,
  parameter int DATA_W   = 8,
  parameter int LOW_MARK = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  input  logic              fa_set,
  output logic              fa_pending,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eop,
  output logic              rd_abort,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  input  logic              stat_rd,
  output logic              irq,
  output logic              ovf
);
  logic    full, push, pop;
  tx_tag_t in_tag, head_tag;
  logic [DATA_W-1:0] head_data;

  assign push = wr_valid && !full;
  assign pop  = rd_ready && !empty;

  always_comb begin
    in_tag.eop   = wr_eop;
    in_tag.abort = fa_pending;
  end

  tx_tag_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .in_data(wr_data), .in_tag(in_tag),
    .out_data(head_data), .out_tag(head_tag)
  );

  tx_tag_fifo_level #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .stat_clr(stat_rd),
    .count(level), .full(full), .empty(empty), .irq(irq)
  );

  tx_tag_fifo_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_try(wr_valid), .accepted(push),
    .fa_set(fa_set), .stat_clr(stat_rd),
    .fa_pending(fa_pending), .ovf(ovf)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;
  assign rd_data  = empty ? '0 : head_data;
  assign rd_eop   = !empty && head_tag.eop;
  assign rd_abort = !empty && head_tag.abort;
endmodule

// File: rtl/tx_tag_fifo_chk.sv
module tx_tag_fifo_chk #(
  parameter int DEPTH    = 19,
  parameter int LOW_MARK = 4,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             fa_set,
  input logic             fa_pending,
  input logic             rd_ready,
  input logic             empty,
  input logic [CNT_W-1:0] level,
  input logic             irq,
  input logic             ovf
);
  // R2: the count never exceeds the capacity
  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  // R2: no space is offered at capacity
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (rst)
    int'(level) == DEPTH |-> !wr_ready);

  // R5: a consumed abort request does not linger
  a_r5_fa_consumed: assert property (@(posedge clk) disable iff (rst)
    (fa_pending && wr_valid && wr_ready && !fa_set) |=> !fa_pending);

  // R6: a refused write is always reported
  a_r6_ovf_on_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> ovf);

  // R7: the interrupt only rises on the downward crossing
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (int'(level) == LOW_MARK && int'($past(level)) == LOW_MARK + 1));

  // R9/R10: the count moves by at most one per cycle
  a_r10_level_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(level) <= int'($past(level)) + 1 && int'(level) + 1 >= int'($past(level))));

  // R11: draining an empty queue leaves it empty
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_ready && !wr_valid) |=> empty);
endmodule

bind tx_tag_fifo tx_tag_fifo_chk #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .fa_set(fa_set), .fa_pending(fa_pending), .rd_ready(rd_ready),
  .empty(empty), .level(level), .irq(irq), .ovf(ovf)
);

// File: tb/tx_tag_fifo_bench.sv
module tx_tag_fifo_bench;
  localparam int DEPTH = 19;
  localparam int MARK  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, wr_eop = 0, fa_set = 0, rd_ready = 0, stat_rd = 0;
  logic [7:0] wr_data = '0;
  logic wr_ready, fa_pending, rd_valid, rd_eop, rd_abort, empty, irq, ovf;
  logic [7:0] rd_data;
  logic [4:0] level;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state: {abort, eop, data}
  logic [9:0] mq[$];
  bit m_irq = 0, m_ovf = 0, m_fa = 0;

  always #5 clk = ~clk;

  tx_tag_fifo u_tx_tag_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_eop(wr_eop), .fa_set(fa_set), .fa_pending(fa_pending),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_eop(rd_eop),
    .rd_abort(rd_abort), .empty(empty), .level(level), .stat_rd(stat_rd),
    .irq(irq), .ovf(ovf)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = mq.size();
    check("R10", "level", int'(level), n);
    check("R2", "wr_ready", int'(wr_ready), int'(n < DEPTH));
    check("R11", "empty", int'(empty), int'(n == 0));
    check("R3", "rd_valid", int'(rd_valid), int'(n != 0));
    check("R7", "irq", int'(irq), int'(m_irq));
    check("R6", "ovf", int'(ovf), int'(m_ovf));
    check("R5", "fa_pending", int'(fa_pending), int'(m_fa));
    if (n != 0) begin
      check("R3", "rd_data", int'(rd_data), int'(mq[0][7:0]));
      check("R4", "rd_eop", int'(rd_eop), int'(mq[0][8]));
      check("R5", "rd_abort", int'(rd_abort), int'(mq[0][9]));
    end
  endtask

  task automatic cyc(input bit wv, input logic [7:0] wd, input bit eop,
                     input bit fa, input bit rr, input bit sr);
    int n;
    bit push, pop;
    @(negedge clk);
    wr_valid = wv; wr_data = wd; wr_eop = eop; fa_set = fa; rd_ready = rr; stat_rd = sr;
    @(posedge clk);
    #1;
    n    = mq.size();
    push = wv && (n < DEPTH);
    pop  = rr && (n > 0);
    if (n == MARK + 1 && pop && !push) m_irq = 1;
    else if (sr)                       m_irq = 0;
    if (wv && !push) m_ovf = 1;
    else if (sr)     m_ovf = 0;
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back({m_fa, eop, wd});
    if (fa)        m_fa = 1;
    else if (push) m_fa = 0;
    compare_all();
  endtask

  task automatic fill_to(input int n, input int seed);
    while (mq.size() < n) cyc(1, 8'(seed * 29 + mq.size() * 7 + 3), (mq.size() % 3) == 2, 0, 0, 0);
  endtask

  task automatic drain_all();
    while (mq.size() > 0) cyc(0, 8'h00, 0, 0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check("R1", "level", int'(level), 0);
    check("R1", "empty", int'(empty), 1);
    check("R1", "rd_valid", int'(rd_valid), 0);
    check("R1", "wr_ready", int'(wr_ready), 1);
    check("R1", "irq/ovf/fa", int'({irq, ovf, fa_pending}), 0);

    // R2 capacity, R4 marker capture
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i * 13 + 7), (i % 5) == 4, 0, 0, 0);
    check("R2", "full level", int'(level), DEPTH);
    // R6 overflow drop
    cyc(1, 8'hAA, 1, 0, 0, 0);
    check("R6", "ovf after drop", int'(ovf), 1);
    check("R6", "level after drop", int'(level), DEPTH);
    // R8 clear by status read
    cyc(0, 8'h00, 0, 0, 0, 1);
    check("R8", "ovf cleared", int'(ovf), 0);
    // R8 set wins against clear
    cyc(1, 8'hBB, 0, 0, 0, 1);
    check("R8", "ovf set beats clear", int'(ovf), 1);
    cyc(0, 8'h00, 0, 0, 0, 1);

    // R3/R7 drain through the threshold
    while (mq.size() > MARK + 1) cyc(0, 8'h00, 0, 0, 1, 0);
    check("R7", "irq above mark", int'(irq), 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    check("R7", "irq at crossing", int'(irq), 1);
    drain_all();
    // R11 drain on empty
    cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    check("R11", "level stays 0", int'(level), 0);
    cyc(0, 8'h00, 0, 0, 0, 1);
    check("R8", "irq cleared", int'(irq), 0);
    // R7 rising through the mark does not fire
    fill_to(10, 1);
    check("R7", "irq after fill", int'(irq), 0);
    // R8 crossing and status read on one edge
    while (mq.size() > MARK + 1) cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(0, 8'h00, 0, 0, 1, 1);
    check("R8", "irq set beats clear", int'(irq), 1);
    drain_all();
    cyc(0, 8'h00, 0, 0, 0, 1);

    // R5 abort request handling
    cyc(0, 8'h00, 0, 1, 0, 0);
    check("R5", "armed", int'(fa_pending), 1);
    cyc(1, 8'h51, 0, 1, 0, 0);
    check("R5", "re-armed on write edge", int'(fa_pending), 1);
    cyc(1, 8'h52, 1, 0, 0, 0);
    check("R5", "consumed", int'(fa_pending), 0);
    cyc(1, 8'h53, 0, 0, 0, 0);
    check("R5", "first tagged", int'(rd_abort), 1);
    drain_all();
    // R5 dropped write keeps the request
    fill_to(DEPTH, 2);
    cyc(0, 8'h00, 0, 1, 0, 0);
    cyc(1, 8'h77, 0, 0, 0, 0);
    check("R5", "drop keeps request", int'(fa_pending), 1);
    cyc(0, 8'h00, 0, 0, 1, 1);
    cyc(1, 8'h78, 0, 0, 0, 0);
    check("R5", "request consumed at space", int'(fa_pending), 0);
    drain_all();

    // R9 write and drain together at every interior level
    for (int lv = 1; lv < DEPTH; lv++) begin
      fill_to(lv, lv);
      cyc(1, 8'(lv), lv[0], 0, 1, 0);
      check("R9", "level held", int'(level), lv);
      drain_all();
      cyc(0, 8'h00, 0, 0, 0, 1);
    end

    // near-exhaustive mixed strobe run
    lf = 16'hACE1;
    for (int k = 0; k < 6000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[1], lf[15:8], lf[2], lf[3] & lf[4] & lf[5],
          (k % 400 < 200) ? (lf[6] & lf[7]) : (lf[6] | lf[7] | lf[9]), lf[11] & lf[12] & lf[14]);
    end
    drain_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule